// File: doc/BRIEF.md
# Wormhole Delta Network Switch Element

This block is one switching element of a multistage delta network. It has four input ports and four output ports, each carrying 4-bit flits with a sideband last-flit bit and a valid/ready handshake. The first flit of a message is its header and holds the destination number. The switch reads only the radix-4 digit that belongs to its own stage. It maps that digit through a small remap register to a physical output, and the message claims that output. The claim holds until the tail flit has left. Other inputs that want the same output wait under backpressure, and none of their flits are lost. A round-robin arbiter chooses among heads that arrive together.

The remap register is static during normal traffic. It is written in-band. A message whose header equals the reserved code 4'hF is a configuration message. The switch absorbs it on the input it arrives on and sends nothing to any output. Its two data flits become the new remap table. Each output has one pipeline register, so a header presented to a free output appears on that output two clock edges later.

Top module: `wdsw_switch`

## Requirements
- R1: While reset is held and after it is released, every out_valid is 0. The remap table starts as the identity, so digit k selects output k.
- R2: A header flit presented on any input with a free target output appears on that output with last and data unchanged, exactly two rising clock edges later. The ready of its input is 1 in the cycle after the header first appears.
- R3: Every flit of a message leaves on the output chosen by its header, in order and without gaps or duplicates. No other message is interleaved on that output until the tail flit, marked by in_last=1, has been accepted.
- R4: When several inputs request the same free output, grants follow round-robin order. After input w has been granted, the next grant goes to the first requester found scanning upward from w+1, wrapping past 3 to 0.
- R5: While out_ready is 0 and out_valid is 1, the output's valid, data and last stay unchanged. The stalled input sees in_ready=0 and keeps its flit.
- R6: A message whose header is 4'hF is a configuration message and no part of it reaches any output. Its data flits D0 then D1, with D1 carrying last, write the table {D1,D0}. Bits [2k+1:2k] give the output that digit k maps to. The table takes effect for headers presented after the tail is accepted.
- R7: Every flit of a configuration message is accepted in the cycle it is presented, whatever the state of the outputs.
- R8: With the default STAGE=0, the routing digit is header bits [3:2] and bits [1:0] are ignored. In general, stage s uses digit (1-s) of the 4-bit destination.
- R9: Messages from different inputs to different outputs proceed at the same time without interfering.
- R10: After a tail leaves an input, the output it held can be granted to a waiting header from another input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset, released synchronously inside |
| in_valid | input | 4 | per-input flit valid |
| in_ready | output | 4 | per-input flit accepted |
| in_data | input | 16 | per-input 4-bit flit, input i at bits [4i+3:4i] |
| in_last | input | 4 | per-input tail marker |
| out_valid | output | 4 | per-output flit valid |
| out_ready | input | 4 | per-output downstream ready |
| out_data | output | 16 | per-output 4-bit flit, output o at bits [4o+3:4o] |
| out_last | output | 4 | per-output tail marker |

## Verification
A wrong path lock shows within a few cycles. A body flit appears on the wrong output, two messages interleave on one output, or an input stalls forever so the output stream comes up short. A corrupted remap table shows only on the next header that uses the affected digit, as a message leaving a different output than the table written by the last configuration message predicts. A stale arbiter pointer shows as a grant order that differs from the rotation as soon as three inputs contend for one output.

// File: rtl/wdsw_pkg.sv
package wdsw_pkg;
  typedef enum logic [1:0] {
    PH_HEAD = 2'd0,
    PH_BODY = 2'd1,
    PH_CFG  = 2'd2
  } wdsw_phase_t;
endpackage

// File: rtl/wdsw_rr_arb.sv
module wdsw_rr_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] gidx
);
  logic [IW-1:0] ptr_q, ptr_d;
  logic          found;

  always_comb begin
    grant = '0;
    gidx  = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = int'(ptr_q) + k;
      if (j >= N) j = j - N;
      if (!found && req[j]) begin
        found = 1'b1;
        gidx  = IW'(j);
      end
    end
    if (en && found) grant[gidx] = 1'b1;
  end

  always_comb begin
    ptr_d = ptr_q;
    if (en && found) begin
      if (int'(gidx) == N - 1) ptr_d = '0;
      else                     ptr_d = gidx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/wdsw_out_reg.sv
module wdsw_out_reg #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  input  logic         ready,
  output logic         acc,
  output logic         q_valid,
  output logic [W-1:0] q
);
  logic         v_q, v_d;
  logic [W-1:0] d_q, d_d;

  assign acc = !v_q || ready;

  always_comb begin
    v_d = v_q;
    d_d = d_q;
    if (acc) begin
      v_d = ld;
      if (ld) d_d = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= v_d;
  end

  always_ff @(posedge clk) begin
    if (acc && ld) d_q <= d_d;
  end

  assign q_valid = v_q;
  assign q       = d_q;
endmodule

// File: rtl/wdsw_in_ctl.sv
module wdsw_in_ctl
  import wdsw_pkg::*;
#(
  parameter int NPORT    = 4,
  parameter int FLIT_W   = 4,
  parameter int STAGE    = 0,
  parameter int CFG_CODE = 15,
  localparam int DIG_W   = $clog2(NPORT),
  localparam int NDIG    = FLIT_W / DIG_W,
  localparam int CFG_W   = NPORT * DIG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [FLIT_W-1:0] in_data,
  input  logic              in_last,
  input  logic [CFG_W-1:0]  remap,
  input  logic              path_ok,
  output logic              in_ready,
  output logic              req,
  output logic [DIG_W-1:0]  tgt,
  output logic              fwd,
  output logic              cfg_we,
  output logic [CFG_W-1:0]  cfg_val
);
  localparam int DIG_LSB = (NDIG - 1 - STAGE) * DIG_W;

  wdsw_phase_t      ph_q, ph_d;
  logic [DIG_W-1:0] tgt_q, tgt_d;
  logic [CFG_W-1:0] sh_q, sh_d;
  logic             is_cfg_hdr, in_cfg, xfer;
  logic [DIG_W-1:0] digit;
  logic [CFG_W-1:0] sh_next;

  assign digit      = in_data[DIG_LSB +: DIG_W];
  assign is_cfg_hdr = (ph_q == PH_HEAD) && (in_data == FLIT_W'(CFG_CODE));
  assign in_cfg     = is_cfg_hdr || (ph_q == PH_CFG);
  assign tgt        = (ph_q == PH_HEAD) ? remap[digit*DIG_W +: DIG_W] : tgt_q;
  assign req        = in_valid && (ph_q == PH_HEAD) && !is_cfg_hdr;
  assign in_ready   = in_cfg ? 1'b1 : path_ok;
  assign xfer       = in_valid && in_ready;
  assign fwd        = xfer && !in_cfg;

  generate
    if (CFG_W > FLIT_W) begin : g_wide
      assign sh_next = {in_data, sh_q[CFG_W-1:FLIT_W]};
    end else begin : g_narrow
      assign sh_next = in_data[CFG_W-1:0];
    end
  endgenerate

  always_comb begin
    ph_d    = ph_q;
    tgt_d   = tgt_q;
    sh_d    = sh_q;
    cfg_we  = 1'b0;
    cfg_val = sh_next;
    if (xfer) begin
      unique case (ph_q)
        PH_HEAD: begin
          if (is_cfg_hdr) begin
            sh_d = '0;
            ph_d = in_last ? PH_HEAD : PH_CFG;
          end else begin
            tgt_d = tgt;
            ph_d  = in_last ? PH_HEAD : PH_BODY;
          end
        end
        PH_BODY: begin
          if (in_last) ph_d = PH_HEAD;
        end
        PH_CFG: begin
          sh_d = sh_next;
          if (in_last) begin
            cfg_we = 1'b1;
            ph_d   = PH_HEAD;
          end
        end
        default: ph_d = PH_HEAD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_HEAD;
    else        ph_q <= ph_d;
  end

  always_ff @(posedge clk) begin
    if (xfer) begin
      tgt_q <= tgt_d;
      sh_q  <= sh_d;
    end
  end
endmodule

// File: rtl/wdsw_switch.sv
module wdsw_switch #(
  parameter int NPORT    = 4,
  parameter int FLIT_W   = 4,
  parameter int STAGE    = 0,
  parameter int CFG_CODE = 15,
  localparam int DIG_W   = $clog2(NPORT),
  localparam int CFG_W   = NPORT * DIG_W,
  localparam int OW      = FLIT_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPORT-1:0]        in_valid,
  output logic [NPORT-1:0]        in_ready,
  input  logic [NPORT*FLIT_W-1:0] in_data,
  input  logic [NPORT-1:0]        in_last,
  output logic [NPORT-1:0]        out_valid,
  input  logic [NPORT-1:0]        out_ready,
  output logic [NPORT*FLIT_W-1:0] out_data,
  output logic [NPORT-1:0]        out_last
);
  function automatic logic [CFG_W-1:0] ident_map();
    logic [CFG_W-1:0] m;
    for (int k = 0; k < NPORT; k++) m[k*DIG_W +: DIG_W] = DIG_W'(k);
    return m;
  endfunction

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  logic [CFG_W-1:0]  remap_q, remap_d;
  logic [DIG_W-1:0]  tgt      [NPORT];
  logic [NPORT-1:0]  req_in, fwd, cfg_we, path_ok;
  logic [CFG_W-1:0]  cfg_val  [NPORT];
  logic [NPORT-1:0]  lock_q, lock_d, acc;
  logic [DIG_W-1:0]  owner_q  [NPORT];
  logic [DIG_W-1:0]  owner_d  [NPORT];
  logic [NPORT*DIG_W-1:0] owner_flat;
  logic [NPORT-1:0]  req_col  [NPORT];
  logic [NPORT-1:0]  grant    [NPORT];
  logic [DIG_W-1:0]  gidx     [NPORT];
  logic [NPORT-1:0]  ld;
  logic [OW-1:0]     ld_d     [NPORT];

  // per-input control
  for (genvar i = 0; i < NPORT; i++) begin : g_in
    wdsw_in_ctl #(
      .NPORT(NPORT), .FLIT_W(FLIT_W), .STAGE(STAGE), .CFG_CODE(CFG_CODE)
    ) u_ctl (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .in_valid (in_valid[i]),
      .in_data  (in_data[i*FLIT_W +: FLIT_W]),
      .in_last  (in_last[i]),
      .remap    (remap_q),
      .path_ok  (path_ok[i]),
      .in_ready (in_ready[i]),
      .req      (req_in[i]),
      .tgt      (tgt[i]),
      .fwd      (fwd[i]),
      .cfg_we   (cfg_we[i]),
      .cfg_val  (cfg_val[i])
    );
  end

  // an input may move a flit only when it owns its target and the target can take it
  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      path_ok[i] = lock_q[tgt[i]] && (owner_q[tgt[i]] == DIG_W'(i)) && acc[tgt[i]];
    end
  end

  // request matrix, transposed per output
  always_comb begin
    for (int o = 0; o < NPORT; o++) begin
      for (int i = 0; i < NPORT; i++) begin
        req_col[o][i] = req_in[i] && (tgt[i] == DIG_W'(o));
      end
    end
  end

  // remap register: lowest-index input wins when two commit together
  always_comb begin
    remap_d = remap_q;
    for (int i = NPORT - 1; i >= 0; i--) begin
      if (cfg_we[i]) remap_d = cfg_val[i];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   remap_q <= ident_map();
    else if (|cfg_we)  remap_q <= remap_d;
  end

  // per-output allocation and pipeline register
  for (genvar o = 0; o < NPORT; o++) begin : g_out
    wdsw_rr_arb #(.N(NPORT)) u_arb (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .en    (!lock_q[o]),
      .req   (req_col[o]),
      .grant (grant[o]),
      .gidx  (gidx[o])
    );

    always_comb begin
      lock_d[o]  = lock_q[o];
      owner_d[o] = owner_q[o];
      if (!lock_q[o]) begin
        if (|grant[o]) begin
          lock_d[o]  = 1'b1;
          owner_d[o] = gidx[o];
        end
      end else if (fwd[owner_q[o]] && in_last[owner_q[o]]) begin
        lock_d[o] = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        lock_q[o]  <= 1'b0;
        owner_q[o] <= '0;
      end else begin
        lock_q[o]  <= lock_d[o];
        owner_q[o] <= owner_d[o];
      end
    end

    assign ld[o]   = lock_q[o] && fwd[owner_q[o]];
    assign ld_d[o] = {in_last[owner_q[o]], in_data[owner_q[o]*FLIT_W +: FLIT_W]};
    assign owner_flat[o*DIG_W +: DIG_W] = owner_q[o];

    logic [OW-1:0] q;
    wdsw_out_reg #(.W(OW)) u_oreg (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .ld      (ld[o]),
      .d       (ld_d[o]),
      .ready   (out_ready[o]),
      .acc     (acc[o]),
      .q_valid (out_valid[o]),
      .q       (q)
    );
    assign out_last[o]                  = q[OW-1];
    assign out_data[o*FLIT_W +: FLIT_W] = q[FLIT_W-1:0];
  end
endmodule

// File: rtl/wdsw_switch_chk.sv
module wdsw_switch_chk #(
  parameter int NPORT  = 4,
  parameter int FLIT_W = 4,
  localparam int DIG_W = $clog2(NPORT)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NPORT-1:0]        out_valid,
  input logic [NPORT-1:0]        out_ready,
  input logic [NPORT*FLIT_W-1:0] out_data,
  input logic [NPORT-1:0]        out_last,
  input logic [NPORT-1:0]        lock,
  input logic [NPORT*DIG_W-1:0]  owner
);
  logic [NPORT-1:0] own_mask [NPORT];
  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      for (int o = 0; o < NPORT; o++) begin
        own_mask[i][o] = lock[o] && (owner[o*DIG_W +: DIG_W] == DIG_W'(i));
      end
    end
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_o
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[o] && !out_ready[o]) |=> (out_valid[o] && $stable(out_data[o*FLIT_W +: FLIT_W]) && $stable(out_last[o]))); // R5
    AST_OWNER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      lock[o] |=> (!lock[o] || $stable(owner[o*DIG_W +: DIG_W]))); // R3
    AST_OUT_FROM_PATH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid[o]) |-> $past(lock[o])); // R2
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_i
    AST_ONE_PATH_PER_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(own_mask[i]) <= 1); // R9
  end
endmodule

bind wdsw_switch wdsw_switch_chk #(.NPORT(NPORT), .FLIT_W(FLIT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last),
  .lock      (lock_q),
  .owner     (owner_flat)
);

// File: tb/wdsw_switch_test.sv
module wdsw_switch_test;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [3:0]        bv, bl, oready;
  logic [3:0][3:0]   bd;
  logic [3:0]        in_ready, out_valid, out_last;
  logic [15:0]       out_data;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  logic mon_on = 1'b0;
  logic [4:0] mq [4][$];
  logic [4:0] expq [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wdsw_switch uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(bv), .in_ready(in_ready), .in_data(bd), .in_last(bl),
    .out_valid(out_valid), .out_ready(oready), .out_data(out_data), .out_last(out_last)
  );

  always @(negedge clk) begin
    if (mon_on) begin
      for (int o = 0; o < 4; o++) begin
        if (out_valid[o] && oready[o]) mq[o].push_back({out_last[o], out_data[o*4 +: 4]});
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 50000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_q(input string req, input int o);
    n_chk++;
    if (mq[o].size() != expq.size()) begin
      n_fail++;
      $display("FAIL %s: output %0d actual %0d flits expected %0d", req, o, mq[o].size(), expq.size());
    end else begin
      for (int k = 0; k < expq.size(); k++) begin
        if (mq[o][k] !== expq[k]) begin
          n_fail++;
          $display("FAIL %s: output %0d flit %0d actual %0h expected %0h", req, o, k, mq[o][k], expq[k]);
          break;
        end
      end
    end
    mq[o].delete();
    expq.delete();
  endtask

  // flit k of the packet is fl[4k+3:4k]
  task automatic drive_pkt(input int p, input logic [15:0] fl, input int n);
    for (int k = 0; k < n; k++) begin
      bv[p] = 1'b1;
      bd[p] = fl[4*k +: 4];
      bl[p] = (k == n - 1);
      @(negedge clk);
      while (!in_ready[p]) @(negedge clk);
      @(posedge clk); #1;
    end
    bv[p] = 1'b0;
    bl[p] = 1'b0;
  endtask

  task automatic push_exp(input logic [15:0] fl, input int n);
    for (int k = 0; k < n; k++) expq.push_back({(k == n - 1) ? 1'b1 : 1'b0, fl[4*k +: 4]});
  endtask

  task automatic settle();
    repeat (8) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 out_valid during reset", out_valid, 4'h0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    mon_on = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after reset", out_valid, 4'h0);
    @(posedge clk); #1;
  endtask

  task automatic t_latency();
    bv[0] = 1'b1; bd[0] = 4'b1001; bl[0] = 1'b1;   // digit 2, single flit
    @(negedge clk);
    @(negedge clk);
    chk("R2 not yet valid after one edge", out_valid[2], 1'b0);
    chk("R2 ready after grant", in_ready[0], 1'b1);
    @(posedge clk); #1;
    bv[0] = 1'b0; bl[0] = 1'b0;
    @(negedge clk);
    chk("R2 valid two edges after head", out_valid[2], 1'b1);
    chk("R2 head data", {out_last[2], out_data[11:8]}, 5'h19);
    settle();
    mq[2].delete();
  endtask

  task automatic t_parallel();
    fork
      drive_pkt(0, 16'h0A_5, 3);   // digit 1
      drive_pkt(1, 16'h0B_9, 3);   // digit 2
      drive_pkt(2, 16'h0C_D, 3);   // digit 3
      drive_pkt(3, 16'h0D_1, 3);   // digit 0
    join
    settle();
    push_exp(16'h0A_5, 3); chk_q("R9 input0 to output1", 1);
    push_exp(16'h0B_9, 3); chk_q("R9 input1 to output2", 2);
    push_exp(16'h0C_D, 3); chk_q("R9 input2 to output3", 3);
    push_exp(16'h0D_1, 3); chk_q("R9 input3 to output0", 0);
  endtask

  task automatic t_wormhole();
    fork
      drive_pkt(0, 16'h3218, 4);
      begin
        @(posedge clk); #1;
        drive_pkt(1, 16'h0768, 3);
      end
    join
    settle();
    push_exp(16'h3218, 4); push_exp(16'h0768, 3);
    chk_q("R3 R10 no interleave and release", 2);
  endtask

  task automatic t_round_robin();
    drive_pkt(1, 16'h0010, 2);      // sets pointer past input 1
    settle();
    mq[0].delete();
    fork
      drive_pkt(0, 16'h0000, 2);
      drive_pkt(2, 16'h0020, 2);
      drive_pkt(3, 16'h0030, 2);
    join
    settle();
    push_exp(16'h0020, 2); push_exp(16'h0030, 2); push_exp(16'h0000, 2);
    chk_q("R4 round-robin order 2,3,0", 0);
  endtask

  task automatic t_backpressure();
    oready[1] = 1'b0;
    fork
      drive_pkt(3, 16'h0CB4, 3);
      begin
        repeat (5) @(negedge clk);
        chk("R5 held valid", out_valid[1], 1'b1);
        chk("R5 held data", {out_last[1], out_data[7:4]}, 5'h04);
        chk("R5 input stalled", in_ready[3], 1'b0);
        @(negedge clk);
        chk("R5 data still held", {out_valid[1], out_data[7:4]}, 5'h14);
        @(posedge clk); #1;
        oready[1] = 1'b1;
      end
    join
    settle();
    push_exp(16'h0CB4, 3);
    chk_q("R5 no loss under stall", 1);
  endtask

  task automatic send_cfg(input int p, input logic [7:0] tbl, input string req);
    logic [11:0] fl;
    int stalls;
    fl = {tbl, 4'hF};
    stalls = 0;
    for (int k = 0; k < 3; k++) begin
      bv[p] = 1'b1; bd[p] = fl[4*k +: 4]; bl[p] = (k == 2);
      @(negedge clk);
      if (!in_ready[p]) stalls++;
      while (!in_ready[p]) @(negedge clk);
      @(posedge clk); #1;
    end
    bv[p] = 1'b0; bl[p] = 1'b0;
    chk({req, " config accepted without stall"}, stalls, 0);
  endtask

  task automatic t_config();
    int tot;
    // keep output 0 busy under backpressure during the config message
    oready[0] = 1'b0;
    fork
      drive_pkt(3, 16'h0071, 2);
      begin
        @(posedge clk); #1;
        send_cfg(2, 8'h1B, "R7");   // digit k -> output 3-k
      end
    join_any
    oready[0] = 1'b1;
    settle();
    push_exp(16'h0071, 2); chk_q("R7 blocked packet intact", 0);
    tot = mq[0].size() + mq[1].size() + mq[2].size() + mq[3].size();
    chk("R6 config not forwarded", tot, 0);
    drive_pkt(0, 16'h0063, 2);      // digit 0 -> now output 3
    settle();
    push_exp(16'h0063, 2); chk_q("R6 remapped digit0 to output3", 3);
    send_cfg(1, 8'hE4, "R7");        // restore identity
    settle();
    drive_pkt(2, 16'h0042, 2);
    settle();
    push_exp(16'h0042, 2); chk_q("R6 identity restored", 0);
  endtask

  task automatic t_digit();
    drive_pkt(1, 16'h0957, 3);      // bits[3:2]=01 -> output 1, low bits ignored
    settle();
    push_exp(16'h0957, 3); chk_q("R8 stage digit bits 3:2", 1);
  endtask

  initial begin
    rst_n = 1'b0; bv = '0; bl = '0; bd = '0; oready = 4'hF;
    repeat (3) @(posedge clk);
    t_reset();
    t_latency();
    t_parallel();
    t_wormhole();
    t_round_robin();
    t_backpressure();
    t_config();
    t_digit();
    summary();
    $finish;
  end
endmodule